// File: doc/BRIEF.md
# Default Control Endpoint Status and Command Register

This block holds the handshake state of a USB device's default control endpoint. A CPU writes one byte at a time through a write strobe and data byte and always sees the current state on an 8-bit read bus. On the other side, the packet engine reports four single-cycle events: an OUT packet has landed in the receive buffer, the queued IN packet has gone out, a STALL handshake has been sent, and the current control transfer has finished. The block also drives a stall request back to the engine.

Each bit follows its own rule. Some bits are set by hardware and cleared only by a separate write-one service strobe. Some are set by firmware and cleared by hardware. One is cleared by writing zero. A single interrupt line pulses when a packet arrives, when a queued IN packet completes, or when a transfer ends before firmware has marked its data stage done. A synchronous bus-reset input clears everything at once.

Top module: `ep0_status_ctl`

## Requirements
- R1: Bit 0 (rx_ready) is set one cycle after `pkt_rx_evt`. A write with bit 0 set or clear has no effect on it. It clears only after a write with bit 6 = 1.
- R2: Bit 1 (tx_ready) is set by a write with bit 1 = 1 and cleared one cycle after `pkt_tx_evt`. A write with bit 1 = 0 leaves it unchanged.
- R3: Bit 2 (stall_done) is set one cycle after `stall_sent_evt`. A write with bit 2 = 0 clears it, and a write with bit 2 = 1 leaves it unchanged.
- R4: Bit 5 (stall_cmd) is set by a write with bit 5 = 1 and is driven out on `stall_req`. It clears itself one cycle after `stall_sent_evt`. A write with bit 5 = 0 does not clear it.
- R5: Bit 3 (last_data) is set by a write with bit 3 = 1 and cleared one cycle after `xfer_end_evt`. A write with bit 3 = 0 leaves it unchanged.
- R6: Bit 4 (early_end) is set one cycle after `xfer_end_evt` if last_data was 0 at that edge. It is not set if last_data was 1. Only a write with bit 7 = 1 clears it, and bit 4 of a write is ignored.
- R7: Read bits 6 and 7 (the two service strobes) always read 0.
- R8: `irq` is high for exactly the cycles in which rx_ready has just risen, tx_ready has just fallen, or early_end has just risen, as seen on `status_rd`.
- R9: When a packet-engine event and a CPU write act on the same bit in the same cycle, the engine event wins.
- R10: `bus_reset` clears all status and command bits on the next edge, and the clearing raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_reset | input | 1 | Synchronous clear of all bits, raises no interrupt |
| wr_stb | input | 1 | CPU byte write strobe |
| wr_byte | input | 8 | CPU write data |
| status_rd | output | 8 | Current register value |
| pkt_rx_evt | input | 1 | OUT data packet received |
| pkt_tx_evt | input | 1 | Queued IN packet transmitted |
| stall_sent_evt | input | 1 | STALL handshake transmitted |
| xfer_end_evt | input | 1 | Control transfer finished |
| stall_req | output | 1 | Request to the engine to answer with STALL |
| irq | output | 1 | Interrupt pulse |

## Verification
The assertions assume that every engine event and the write strobe are sampled on the rising edge and that `bus_reset` outranks all of them. A rise seen on the read bus is always taken to come from a hardware event or a write, never from a reset. The bench changes inputs only on the falling edge and holds each event for one cycle. A sweep applies every write byte under every combination of the four engine events, so same-cycle collisions are covered in every pairing. `bus_reset` is asserted only between phases, where a reference model tracks the effect of the reset.

// File: rtl/ep0_pkg.sv
package ep0_pkg;
  localparam int REG_W  = 8;
  localparam int NFLAG  = 6;
  // Flag indices double as bit positions in the read byte.
  localparam int F_RX   = 0;
  localparam int F_TX   = 1;
  localparam int F_SDN  = 2;
  localparam int F_LAST = 3;
  localparam int F_EARLY= 4;
  localparam int F_SCMD = 5;
  // Service strobe positions in a write byte.
  localparam int S_RX   = 6;
  localparam int S_EARLY= 7;

  typedef struct packed {
    logic set_tx;
    logic set_last;
    logic set_scmd;
    logic zero_sdn;
    logic svc_rx;
    logic svc_early;
  } wr_cmd_t;

  function automatic wr_cmd_t decode_write(input logic [REG_W-1:0] d);
    wr_cmd_t c;
    c.set_tx    = d[F_TX];
    c.set_last  = d[F_LAST];
    c.set_scmd  = d[F_SCMD];
    c.zero_sdn  = ~d[F_SDN];
    c.svc_rx    = d[S_RX];
    c.svc_early = d[S_EARLY];
    return c;
  endfunction

  function automatic logic [REG_W-1:0] pack_status(input logic [NFLAG-1:0] f);
    return {{(REG_W-NFLAG){1'b0}}, f};
  endfunction

  function automatic logic irq_event(input logic [NFLAG-1:0] prev,
                                     input logic [NFLAG-1:0] cur);
    return (cur[F_RX] & ~prev[F_RX]) | (prev[F_TX] & ~cur[F_TX]) |
           (cur[F_EARLY] & ~prev[F_EARLY]);
  endfunction
endpackage

// File: rtl/ep0_flag_cell.sv
module ep0_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_rst,
  input  logic hw_set,
  input  logic hw_clr,
  input  logic sw_set,
  input  logic sw_clr,
  output logic q
);
  // Priority: bus reset, then engine events, then CPU writes.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= 1'b0;
    else if (bus_rst) q <= 1'b0;
    else if (hw_set)  q <= 1'b1;
    else if (hw_clr)  q <= 1'b0;
    else if (sw_set)  q <= 1'b1;
    else if (sw_clr)  q <= 1'b0;
  end
endmodule

// File: rtl/ep0_irq_gen.sv
module ep0_irq_gen
  import ep0_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_rst,
  input  logic [NFLAG-1:0] flags,
  output logic             irq
);
  logic [NFLAG-1:0] prev_q;
  logic             mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      mask_q <= 1'b0;
    end else begin
      prev_q <= flags;
      mask_q <= bus_rst;
    end
  end

  // A change produced by a bus reset is masked.
  assign irq = ~mask_q & irq_event(prev_q, flags);
endmodule

// File: rtl/ep0_status_ctl.sv
module ep0_status_ctl
  import ep0_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_reset,
  input  logic             wr_stb,
  input  logic [REG_W-1:0] wr_byte,
  output logic [REG_W-1:0] status_rd,
  input  logic             pkt_rx_evt,
  input  logic             pkt_tx_evt,
  input  logic             stall_sent_evt,
  input  logic             xfer_end_evt,
  output logic             stall_req,
  output logic             irq
);
  wr_cmd_t          cmd;
  logic [NFLAG-1:0] flags;
  logic [NFLAG-1:0] hw_set, hw_clr, sw_set, sw_clr;

  // Named event wires for the checks below.
  logic early_hit;

  assign cmd       = decode_write(wr_byte);
  assign early_hit = xfer_end_evt & ~flags[F_LAST];

  always_comb begin
    hw_set = '0; hw_clr = '0; sw_set = '0; sw_clr = '0;
    hw_set[F_RX]    = pkt_rx_evt;
    sw_clr[F_RX]    = wr_stb & cmd.svc_rx;
    hw_clr[F_TX]    = pkt_tx_evt;
    sw_set[F_TX]    = wr_stb & cmd.set_tx;
    hw_set[F_SDN]   = stall_sent_evt;
    sw_clr[F_SDN]   = wr_stb & cmd.zero_sdn;
    hw_clr[F_LAST]  = xfer_end_evt;
    sw_set[F_LAST]  = wr_stb & cmd.set_last;
    hw_set[F_EARLY] = early_hit;
    sw_clr[F_EARLY] = wr_stb & cmd.svc_early;
    hw_clr[F_SCMD]  = stall_sent_evt;
    sw_set[F_SCMD]  = wr_stb & cmd.set_scmd;
  end

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    ep0_flag_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .bus_rst(bus_reset),
      .hw_set (hw_set[i]),
      .hw_clr (hw_clr[i]),
      .sw_set (sw_set[i]),
      .sw_clr (sw_clr[i]),
      .q      (flags[i])
    );
  end

  ep0_irq_gen u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .bus_rst(bus_reset),
    .flags  (flags),
    .irq    (irq)
  );

  assign status_rd = pack_status(flags);
  assign stall_req = flags[F_SCMD];

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd[F_RX] && !bus_reset && !(wr_stb && wr_byte[S_RX])) |=> status_rd[F_RX]); // R1
  AST_TX_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_tx_evt |=> !status_rd[F_TX]); // R2
  AST_STALL_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_sent_evt && !bus_reset) |=> status_rd[F_SDN]); // R3
  AST_STALL_CMD_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    stall_sent_evt |=> !stall_req); // R4
  AST_EARLY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_end_evt && !status_rd[F_LAST] && !bus_reset) |=> status_rd[F_EARLY]); // R6
  AST_RX_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_rd[F_RX]) |-> irq); // R8
  AST_BUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> (status_rd == '0) && !irq); // R10
endmodule

// File: tb/tb_ep0_status_ctl.sv
module tb_ep0_status_ctl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_reset = 1'b0;
  logic       wr_stb = 1'b0;
  logic [7:0] wr_byte = 8'h00;
  logic [7:0] status_rd;
  logic       pkt_rx_evt = 1'b0, pkt_tx_evt = 1'b0;
  logic       stall_sent_evt = 1'b0, xfer_end_evt = 1'b0;
  logic       stall_req, irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ep0_status_ctl dut (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset),
    .wr_stb(wr_stb), .wr_byte(wr_byte), .status_rd(status_rd),
    .pkt_rx_evt(pkt_rx_evt), .pkt_tx_evt(pkt_tx_evt),
    .stall_sent_evt(stall_sent_evt), .xfer_end_evt(xfer_end_evt),
    .stall_req(stall_req), .irq(irq)
  );

  // Reference state, one variable per bit.
  logic m_rx = 0, m_tx = 0, m_sd = 0, m_le = 0, m_ee = 0, m_sc = 0;
  logic m_irq = 0;

  function automatic logic [7:0] m_byte();
    return {2'b00, m_sc, m_ee, m_le, m_sd, m_tx, m_rx};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // Drive one cycle of stimulus, step the model, then check after the edge.
  task automatic cyc(input logic br, input logic w, input logic [7:0] d,
                     input logic rx, input logic tx, input logic se, input logic xe);
    logic n_rx, n_tx, n_sd, n_le, n_ee, n_sc;
    bus_reset = br; wr_stb = w; wr_byte = d;
    pkt_rx_evt = rx; pkt_tx_evt = tx; stall_sent_evt = se; xfer_end_evt = xe;
    n_rx = br ? 1'b0 : rx ? 1'b1 : (w && d[6]) ? 1'b0 : m_rx;
    n_tx = br ? 1'b0 : tx ? 1'b0 : (w && d[1]) ? 1'b1 : m_tx;
    n_sd = br ? 1'b0 : se ? 1'b1 : (w && !d[2]) ? 1'b0 : m_sd;
    n_le = br ? 1'b0 : xe ? 1'b0 : (w && d[3]) ? 1'b1 : m_le;
    n_ee = br ? 1'b0 : (xe && !m_le) ? 1'b1 : (w && d[7]) ? 1'b0 : m_ee;
    n_sc = br ? 1'b0 : se ? 1'b0 : (w && d[5]) ? 1'b1 : m_sc;
    m_irq = !br && ((n_rx && !m_rx) || (m_tx && !n_tx) || (n_ee && !m_ee));
    {m_rx, m_tx, m_sd, m_le, m_ee, m_sc} = {n_rx, n_tx, n_sd, n_le, n_ee, n_sc};
    @(negedge clk);
    bus_reset = 0; wr_stb = 0; wr_byte = 0;
    pkt_rx_evt = 0; pkt_tx_evt = 0; stall_sent_evt = 0; xfer_end_evt = 0;
  endtask

  task automatic wr(input logic [7:0] d); cyc(0, 1, d, 0, 0, 0, 0); endtask
  task automatic idle(); cyc(0, 0, 8'h00, 0, 0, 0, 0); endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 reset value", status_rd, 8'h00);
    check("R8 no irq at reset", {7'd0, irq}, 8'h00);

    // R1: set by receive, bit-0 write ignored, service clears
    cyc(0, 0, 0, 1, 0, 0, 0);
    check("R1 rx set", status_rd, 8'h01);
    check("R8 irq on rx rise", {7'd0, irq}, 8'h01);
    idle();
    check("R8 irq single pulse", {7'd0, irq}, 8'h00);
    wr(8'h00);
    check("R1 write 0 ignored", status_rd & 8'h01, 8'h01);
    wr(8'h40);
    check("R1 service clears", status_rd, 8'h00);
    check("R7 strobes read 0", status_rd & 8'hC0, 8'h00);

    // R2: firmware set, engine clear with interrupt
    wr(8'h02);
    check("R2 tx set", status_rd, 8'h02);
    wr(8'h00);
    check("R2 write 0 ignored", status_rd, 8'h02);
    cyc(0, 0, 0, 0, 1, 0, 0);
    check("R2 tx cleared", status_rd, 8'h00);
    check("R8 irq on tx fall", {7'd0, irq}, 8'h01);

    // R4 and R3
    wr(8'h20);
    check("R4 stall cmd set", {stall_req, status_rd[6:0]}, 8'hA0);
    cyc(0, 0, 0, 0, 0, 1, 0);
    check("R4 cmd dropped, R3 sent set", {stall_req, status_rd[6:0]}, 8'h04);
    wr(8'h04);
    check("R3 write 1 keeps", status_rd, 8'h04);
    wr(8'h00);
    check("R3 write 0 clears", status_rd, 8'h00);

    // R5 and R6
    wr(8'h08);
    check("R5 last set", status_rd, 8'h08);
    cyc(0, 0, 0, 0, 0, 0, 1);
    check("R5 last cleared, R6 no early", status_rd, 8'h00);
    check("R8 no irq", {7'd0, irq}, 8'h00);
    cyc(0, 0, 0, 0, 0, 0, 1);
    check("R6 early set", status_rd, 8'h10);
    check("R8 irq on early", {7'd0, irq}, 8'h01);
    wr(8'h00);
    check("R6 bit4 write ignored", status_rd, 8'h10);
    wr(8'h80);
    check("R6 service clears", status_rd, 8'h00);

    // R9: collisions
    cyc(0, 1, 8'h40, 1, 0, 0, 0);
    check("R9 rx set beats service", status_rd, 8'h01);
    cyc(0, 1, 8'h02, 0, 1, 0, 0);
    check("R9 tx clear beats set", status_rd & 8'h02, 8'h00);
    cyc(0, 1, 8'h20, 0, 0, 1, 0);
    check("R9 stall event beats cmd set", {stall_req, status_rd[6:0]}, 8'h05);

    // R10: bus reset clears without interrupt
    wr(8'h2A);
    cyc(1, 0, 0, 0, 0, 0, 0);
    check("R10 bus reset clears", status_rd, 8'h00);
    check("R10 no irq", {7'd0, irq}, 8'h00);

    // Sweep: every write byte under every event combination.
    for (int w = 0; w < 256; w++) begin
      for (int e = 0; e < 16; e++) begin
        cyc(0, 1, w[7:0], e[0], e[1], e[2], e[3]);
        check("R9 sweep value", status_rd, m_byte());
        check("R8 sweep irq", {6'd0, stall_req, irq}, {6'd0, m_sc, m_irq});
      end
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule